// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for every beat of a synchronous DRAM burst. A one-cycle start request carries a starting column, a length code, an ordering flag (wrapping increment or XOR interleave) and a device width code. From the next clock on, the block presents one column per cycle with a valid flag and marks the final beat. A memory controller places it next to its command issue logic and takes the column address for each read or write beat from here.

Fixed bursts of 1, 2, 4 or 8 beats reorder only the low column bits inside the aligned block that holds the start column. Bits above that block keep their value. Page bursts walk through every column allowed by the width code and wrap from the top column back to zero. They run until the terminate input stops them. The block refuses a request it cannot serve and reports the refusal with a one-cycle pulse. A new legal request always takes over from a burst in progress.

Top module: `burst_col_seq`

## Requirements
- R1: During and directly after a synchronous active-high reset, `col_valid`, `col_last` and `reject` are 0.
- R2: If `start` with a legal setting is sampled at clock edge n, then after edge n `col_valid` is 1 and `col_addr` holds the start column. Start column bits at or above the configured width read as 0.
- R3: In a sequential fixed burst of length L, beat k carries the start column with its low log2(L) bits replaced by (start + k) mod L. Higher bits stay fixed, so length 4 from 1 gives 1,2,3,0 and length 8 from 5 gives 5,6,7,0,1,2,3,4.
- R4: In an interleaved fixed burst, beat k carries the low log2(L) bits of start XOR k. Higher bits stay fixed, so length 4 from 1 gives 1,0,3,2 and length 8 from 5 gives 5,4,7,6,1,0,3,2.
- R5: `len_code` values 0, 1, 2 and 3 select 1, 2, 4 and 8 beats. `col_last` is 1 only on the final beat, and `col_valid` drops the cycle after it. A one-beat burst asserts `col_last` on its only beat.
- R6: `len_code` 7 selects a page burst, which is sequential only. `width_cfg` 0, 1 and 2 select 10, 9 and 8 column bits. Each beat adds 1 modulo 2^bits, `col_last` stays 0, and `col_addr` bits above the width are 0.
- R7: If `terminate` is 1 at an edge during a burst, `col_valid` is 0 after that edge. If a legal `start` arrives at the same edge, the new burst begins instead.
- R8: Some requests are refused: a page length with interleave, `len_code` 4 to 6, or `width_cfg` 3. For each of these, `reject` is 1 for the following cycle, no burst starts, and a burst already running continues unchanged.
- R9: A legal `start` during an active burst abandons it. The next cycle shows beat 0 of the new burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request for a new burst (one cycle) |
| start_col | input | COL_W | Starting column |
| len_code | input | 3 | Length: 0=1, 1=2, 2=4, 3=8, 7=page |
| ilv | input | 1 | 0 sequential, 1 interleaved |
| width_cfg | input | 2 | Column width: 0=COL_W, 1=COL_W-1, 2=COL_W-2 bits |
| terminate | input | 1 | Ends the active burst |
| col_valid | output | 1 | A beat is presented |
| col_addr | output | COL_W | Column of the current beat |
| col_last | output | 1 | Final beat of a fixed burst |
| reject | output | 1 | Previous request was refused |

## Verification
The hardest case to reach is two requests meeting in one cycle: a terminate or a refused request arriving while a burst is mid-flight, or a legal request cutting a burst short. Directed sequences place a refused request at beat 3 of an 8-beat burst and a terminate in the same cycle as a new start. Randomized bursts that stop observing after a random number of beats then fire the next request at once. This produces restarts at every beat position across all widths, lengths and orderings.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int LEN_W = 3;

  typedef enum logic [2:0] {
    BL_1    = 3'd0,
    BL_2    = 3'd1,
    BL_4    = 3'd2,
    BL_8    = 3'd3,
    BL_PAGE = 3'd7
  } blen_e;

  typedef enum logic [1:0] {
    WCFG_FULL  = 2'd0,
    WCFG_LESS1 = 2'd1,
    WCFG_LESS2 = 2'd2,
    WCFG_RSVD  = 2'd3
  } wcfg_e;
endpackage

// File: rtl/burst_cfg_decode.sv
module burst_cfg_decode
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [2:0]       len_code,
  input  logic             ilv,
  input  logic [1:0]       width_cfg,
  output logic             legal,
  output logic             is_page,
  output logic [LEN_W-1:0] len_m1,
  output logic [COL_W-1:0] wmask
);
  logic len_ok;

  always_comb begin
    is_page = 1'b0;
    len_m1  = '0;
    len_ok  = 1'b1;
    case (blen_e'(len_code))
      BL_1:    len_m1 = 3'd0;
      BL_2:    len_m1 = 3'd1;
      BL_4:    len_m1 = 3'd3;
      BL_8:    len_m1 = 3'd7;
      BL_PAGE: is_page = 1'b1;
      default: len_ok = 1'b0;
    endcase
    wmask = {COL_W{1'b1}} >> width_cfg;
    legal = len_ok && (wcfg_e'(width_cfg) != WCFG_RSVD) && !(is_page && ilv);
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] idx,
  input  logic [LEN_W-1:0] len_m1,
  input  logic             is_page,
  input  logic             ilv,
  input  logic [COL_W-1:0] wmask,
  output logic [COL_W-1:0] addr
);
  logic [COL_W-1:0] bmask;
  logic [COL_W-1:0] seq_sum;
  logic [COL_W-1:0] ilv_mix;

  always_comb begin
    bmask   = {{(COL_W-LEN_W){1'b0}}, len_m1};
    seq_sum = base + idx;
    ilv_mix = base ^ idx;
    if (is_page)
      addr = seq_sum & wmask;
    else
      addr = (base & ~bmask) | ((ilv ? ilv_mix : seq_sum) & bmask);
  end
endmodule

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             legal,
  input  logic             terminate,
  input  logic [COL_W-1:0] new_base,
  input  logic [LEN_W-1:0] new_len_m1,
  input  logic             new_page,
  input  logic             new_ilv,
  input  logic [COL_W-1:0] new_wmask,
  output logic [COL_W-1:0] sel_base,
  output logic [COL_W-1:0] sel_idx,
  output logic [LEN_W-1:0] sel_len_m1,
  output logic             sel_page,
  output logic             sel_ilv,
  output logic [COL_W-1:0] sel_wmask,
  output logic             nxt_valid,
  output logic             cur_valid,
  output logic             cur_last,
  output logic             cur_page,
  output logic [COL_W-1:0] cur_wmask
);
  logic [COL_W-1:0] cur_idx;
  logic [COL_W-1:0] lat_base;
  logic [LEN_W-1:0] lat_len_m1;
  logic             lat_ilv;
  logic             load;
  logic             cont;
  logic             nxt_last;

  always_comb begin
    load = start && legal;
    cont = cur_valid && !cur_last && !terminate;
    if (load) begin
      sel_base   = new_base;
      sel_idx    = '0;
      sel_len_m1 = new_len_m1;
      sel_page   = new_page;
      sel_ilv    = new_ilv;
      sel_wmask  = new_wmask;
      nxt_valid  = 1'b1;
      nxt_last   = !new_page && (new_len_m1 == '0);
    end else begin
      sel_base   = lat_base;
      sel_idx    = cur_idx + 1'b1;
      sel_len_m1 = lat_len_m1;
      sel_page   = cur_page;
      sel_ilv    = lat_ilv;
      sel_wmask  = cur_wmask;
      nxt_valid  = cont;
      nxt_last   = cont && !cur_page &&
                   (sel_idx == {{(COL_W-LEN_W){1'b0}}, lat_len_m1});
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_valid  <= 1'b0;
      cur_last   <= 1'b0;
      cur_idx    <= '0;
      lat_base   <= '0;
      lat_len_m1 <= '0;
      cur_page   <= 1'b0;
      lat_ilv    <= 1'b0;
      cur_wmask  <= '0;
    end else begin
      cur_valid <= nxt_valid;
      cur_last  <= nxt_last;
      if (load || cont) cur_idx <= sel_idx;
      if (load) begin
        lat_base   <= new_base;
        lat_len_m1 <= new_len_m1;
        cur_page   <= new_page;
        lat_ilv    <= new_ilv;
        cur_wmask  <= new_wmask;
      end
    end
  end

  a_r5_last_needs_valid: assert property (@(posedge clk) disable iff (rst)
    cur_last |-> cur_valid);

  a_r5_last_ends_burst: assert property (@(posedge clk) disable iff (rst)
    (cur_valid && cur_last && !(start && legal)) |=> !cur_valid);

  a_r7_terminate_stops: assert property (@(posedge clk) disable iff (rst)
    (cur_valid && terminate && !(start && legal)) |=> !cur_valid);

  a_r5_idx_in_range: assert property (@(posedge clk) disable iff (rst)
    (cur_valid && !cur_page) |-> (cur_idx <= {{(COL_W-LEN_W){1'b0}}, lat_len_m1}));

  a_r6_page_not_last: assert property (@(posedge clk) disable iff (rst)
    (cur_valid && cur_page) |-> !cur_last);
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       len_code,
  input  logic             ilv,
  input  logic [1:0]       width_cfg,
  input  logic             terminate,
  output logic             col_valid,
  output logic [COL_W-1:0] col_addr,
  output logic             col_last,
  output logic             reject
);
  logic             dec_legal;
  logic             dec_page;
  logic [LEN_W-1:0] dec_len_m1;
  logic [COL_W-1:0] dec_wmask;
  logic [COL_W-1:0] new_base;
  logic [COL_W-1:0] sel_base;
  logic [COL_W-1:0] sel_idx;
  logic [LEN_W-1:0] sel_len_m1;
  logic             sel_page;
  logic             sel_ilv;
  logic [COL_W-1:0] sel_wmask;
  logic             nxt_valid;
  logic             cur_page;
  logic [COL_W-1:0] cur_wmask;
  logic [COL_W-1:0] gen_addr;
  logic [COL_W-1:0] addr_q;
  logic             reject_q;

  assign new_base = start_col & dec_wmask;

  burst_cfg_decode #(.COL_W(COL_W)) u_dec (
    .len_code (len_code),
    .ilv      (ilv),
    .width_cfg(width_cfg),
    .legal    (dec_legal),
    .is_page  (dec_page),
    .len_m1   (dec_len_m1),
    .wmask    (dec_wmask)
  );

  burst_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .legal     (dec_legal),
    .terminate (terminate),
    .new_base  (new_base),
    .new_len_m1(dec_len_m1),
    .new_page  (dec_page),
    .new_ilv   (ilv),
    .new_wmask (dec_wmask),
    .sel_base  (sel_base),
    .sel_idx   (sel_idx),
    .sel_len_m1(sel_len_m1),
    .sel_page  (sel_page),
    .sel_ilv   (sel_ilv),
    .sel_wmask (sel_wmask),
    .nxt_valid (nxt_valid),
    .cur_valid (col_valid),
    .cur_last  (col_last),
    .cur_page  (cur_page),
    .cur_wmask (cur_wmask)
  );

  burst_addr_gen #(.COL_W(COL_W)) u_gen (
    .base  (sel_base),
    .idx   (sel_idx),
    .len_m1(sel_len_m1),
    .is_page(sel_page),
    .ilv   (sel_ilv),
    .wmask (sel_wmask),
    .addr  (gen_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      reject_q <= 1'b0;
    end else begin
      if (nxt_valid) addr_q <= gen_addr;
      reject_q <= start && !dec_legal;
    end
  end

  assign col_addr = addr_q;
  assign reject   = reject_q;

  a_r8_refused_no_burst: assert property (@(posedge clk) disable iff (rst)
    (start && !dec_legal && !col_valid) |=> (!col_valid && reject));

  a_r6_addr_in_width: assert property (@(posedge clk) disable iff (rst)
    col_valid |-> ((col_addr & ~cur_wmask) == '0));

  a_r6_page_step: assert property (@(posedge clk) disable iff (rst)
    (col_valid && cur_page && !terminate && !start) |=>
      (col_valid && col_addr == (($past(col_addr) + 1'b1) & cur_wmask)));

  a_r9_restart_first_beat: assert property (@(posedge clk) disable iff (rst)
    (start && dec_legal) |=> (col_valid && col_addr == $past(new_base)));
endmodule

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb;
  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [2:0]       len_code = '0;
  logic             ilv = 1'b0;
  logic [1:0]       width_cfg = '0;
  logic             terminate = 1'b0;
  logic             col_valid;
  logic [COL_W-1:0] col_addr;
  logic             col_last;
  logic             reject;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) u_dut (
    .clk(clk), .rst(rst), .start(start), .start_col(start_col),
    .len_code(len_code), .ilv(ilv), .width_cfg(width_cfg),
    .terminate(terminate), .col_valid(col_valid), .col_addr(col_addr),
    .col_last(col_last), .reject(reject)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int beats_of(input logic [2:0] code);
    return (code < 3'd4) ? (1 << code) : 0;
  endfunction

  function automatic logic [COL_W-1:0] ref_addr(input logic [COL_W-1:0] col, input int k,
      input logic [2:0] code, input logic i, input logic [1:0] wc);
    logic [COL_W-1:0] wm, c, kk, m;
    wm = {COL_W{1'b1}} >> wc;
    c  = col & wm;
    kk = COL_W'(k);
    if (code == 3'd7) return (c + kk) & wm;
    m = COL_W'(beats_of(code) - 1);
    return (c & ~m) | ((i ? (c ^ kk) : (c + kk)) & m);
  endfunction

  task automatic burst(input logic [COL_W-1:0] col, input logic [2:0] code, input logic i,
      input logic [1:0] wc, input int nobs, input bit term, input string req);
    int blen;
    blen = beats_of(code);
    start = 1'b1; start_col = col; len_code = code; ilv = i; width_cfg = wc;
    step();
    start = 1'b0;
    for (int k = 0; k < nobs; k++) begin
      chk($sformatf("%s valid beat %0d", req, k), col_valid, 1);
      chk($sformatf("%s addr beat %0d", req, k), col_addr, ref_addr(col, k, code, i, wc));
      chk($sformatf("%s last beat %0d", req, k), col_last, (blen != 0 && k == blen - 1));
      if (k < nobs - 1) step();
    end
    if (blen != 0 && nobs == blen) begin
      step();
      chk($sformatf("%s/R5 valid after last", req), col_valid, 0);
    end else if (term) begin
      terminate = 1'b1;
      step();
      terminate = 1'b0;
      chk($sformatf("%s/R7 valid after terminate", req), col_valid, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) step();
    chk("R1 valid in reset", col_valid, 0);
    chk("R1 last in reset", col_last, 0);
    chk("R1 reject in reset", reject, 0);
    rst = 1'b0;
    step();
    chk("R1 valid after reset", col_valid, 0);

    burst(10'd1, 3'd2, 1'b0, 2'd0, 4, 1'b0, "R3 len4 seq");
    burst(10'd1, 3'd2, 1'b1, 2'd0, 4, 1'b0, "R4 len4 ilv");
    burst(10'd5, 3'd3, 1'b0, 2'd0, 8, 1'b0, "R3 len8 seq");
    burst(10'd5, 3'd3, 1'b1, 2'd0, 8, 1'b0, "R4 len8 ilv");
    burst(10'h2F5, 3'd3, 1'b1, 2'd0, 8, 1'b0, "R4 upper bits");
    burst(10'h2FE, 3'd2, 1'b0, 2'd0, 4, 1'b0, "R3 upper bits");
    burst(10'h03A, 3'd0, 1'b0, 2'd0, 1, 1'b0, "R5 len1");
    burst(10'h003, 3'd1, 1'b1, 2'd0, 2, 1'b0, "R5 len2");
    burst(10'h3C7, 3'd2, 1'b0, 2'd2, 4, 1'b0, "R2 masked start");
    burst(10'h0FE, 3'd7, 1'b0, 2'd2, 4, 1'b1, "R6 page x32");
    burst(10'h3FE, 3'd7, 1'b0, 2'd0, 4, 1'b1, "R6 page x8");
    burst(10'h3FE, 3'd7, 1'b0, 2'd1, 4, 1'b1, "R6 page x16");
    burst(10'h000, 3'd3, 1'b0, 2'd0, 3, 1'b1, "R7 fixed");

    burst(10'h002, 3'd3, 1'b0, 2'd0, 3, 1'b0, "R9 first");
    burst(10'h040, 3'd2, 1'b1, 2'd0, 4, 1'b0, "R9 second");

    burst(10'h000, 3'd7, 1'b0, 2'd0, 3, 1'b0, "R7 pre");
    terminate = 1'b1;
    start = 1'b1; start_col = 10'h010; len_code = 3'd1; ilv = 1'b0; width_cfg = 2'd0;
    step();
    terminate = 1'b0; start = 1'b0;
    chk("R7 start wins valid", col_valid, 1);
    chk("R7 start wins addr", col_addr, 10'h010);
    step();
    chk("R7 start wins addr beat1", col_addr, 10'h011);
    chk("R7 start wins last", col_last, 1);
    step();
    chk("R7 start wins end", col_valid, 0);

    start = 1'b1; start_col = 10'h005; len_code = 3'd7; ilv = 1'b1; width_cfg = 2'd0;
    step(); start = 1'b0;
    chk("R8 page ilv reject", reject, 1);
    chk("R8 page ilv no burst", col_valid, 0);
    step();
    chk("R8 reject one cycle", reject, 0);
    start = 1'b1; len_code = 3'd5; ilv = 1'b0;
    step(); start = 1'b0;
    chk("R8 bad len reject", reject, 1);
    chk("R8 bad len no burst", col_valid, 0);
    start = 1'b1; len_code = 3'd2; width_cfg = 2'd3;
    step(); start = 1'b0;
    chk("R8 bad width reject", reject, 1);
    chk("R8 bad width no burst", col_valid, 0);
    step();

    burst(10'h000, 3'd3, 1'b0, 2'd0, 3, 1'b0, "R8 running");
    start = 1'b1; start_col = 10'h123; len_code = 3'd6; ilv = 1'b0; width_cfg = 2'd0;
    step(); start = 1'b0;
    chk("R8 reject mid burst", reject, 1);
    chk("R8 burst continues valid", col_valid, 1);
    for (int k = 3; k < 8; k++) begin
      chk($sformatf("R8 continue addr beat %0d", k), col_addr, ref_addr(10'h000, k, 3'd3, 1'b0, 2'd0));
      chk($sformatf("R8 continue last beat %0d", k), col_last, (k == 7));
      step();
    end
    chk("R8 continue end", col_valid, 0);

    for (int n = 0; n < 80; n++) begin
      logic [2:0] code;
      logic       ii;
      logic [1:0] wc;
      int         nobs;
      bit         term;
      int         pick;
      pick = $urandom % 5;
      code = (pick == 4) ? 3'd7 : 3'(pick);
      ii   = (code == 3'd7) ? 1'b0 : 1'($urandom % 2);
      wc   = 2'($urandom % 3);
      term = 1'b0;
      if (code == 3'd7) begin
        nobs = 1 + ($urandom % 20);
        term = ($urandom % 2) == 0;
      end else if (beats_of(code) > 1 && ($urandom % 3) == 0) begin
        nobs = 1 + ($urandom % (beats_of(code) - 1));
      end else begin
        nobs = beats_of(code);
      end
      burst(10'($urandom), code, ii, wc, nobs, term, "R9 random");
    end
    terminate = 1'b1;
    step();
    terminate = 1'b0;
    chk("R7 final stop", col_valid, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule